// File: doc/BRIEF.md
# Compact-Encoding Data-Processing Decoder

This block decodes one 32-bit word of the compact instruction set and says whether it belongs to the data-processing class whose second operand is a modified immediate. For words in that class, it picks out the destination and first-source register indices and the set-flags bit. It maps the 4-bit opcode to an operation and resolves the aliases selected by a register index equal to 15. A destination of 15 with the set-flags bit set turns four of the operations into flag-only compares. A first source of 15 turns the two OR forms into moves that ignore operand A. Words outside the class produce no operation and no illegal indication. Expanding the immediate and executing the operation happen in later stages.

Words enter and results leave over valid/ready handshakes, with one register stage between them. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. Its decode appears on the outputs in the next cycle with `out_valid` high. While `out_ready` is low, the result is held unchanged and `in_ready` drops, so the stall reaches back to the producer. `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `cdp_decoder`

## Requirements
- R1: A word is in the class when bits [31:27] are 11110, bit 25 is 0 and bit 15 is 0. For any other word the result has op = 0 (none), illegal = 0, wr_en = 0, setf = 0 and a_unused = 0.
- R2: For a word in the class, rn is bits [19:16] and rd is bits [11:8]. For a legal operation that is not a compare, setf equals bit 20.
- R3: The opcode in bits [24:21] selects the operation, with op codes AND=1, BIC=2, ORR=3, ORN=4, EOR=5, ADD=6, ADC=7, SBC=8, SUB=9, RSB=10. The opcode-to-operation map is 0 AND, 1 BIC, 2 ORR, 3 ORN, 4 EOR, 8 ADD, 10 ADC, 11 SBC, 13 SUB, 14 RSB. Each of these operations sets wr_en = 1.
- R4: Opcodes 5, 6, 7, 9, 12 and 15 give illegal = 1, op = 0, wr_en = 0, setf = 0 and a_unused = 0.
- R5: With bit 20 set and rd = 15, opcodes 0, 4, 8 and 13 decode as TST=11, TEQ=12, CMN=13 and CMP=14 respectively, with wr_en = 0 and setf = 1.
- R6: With rn = 15, opcode 2 decodes as MOV=15 and opcode 3 decodes as MVN=16, with a_unused = 1. Every other result has a_unused = 0.
- R7: A word in the class with a legal opcode, rd = 15 and no compare alias gives illegal = 1, op = 0 and wr_en = 0.
- R8: A result appears with out_valid = 1 in the cycle after its word is accepted. It holds stable while out_ready = 0. in_ready = !out_valid || out_ready.
- R9: After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Decode result present |
| out_ready | input | 1 | Consumer takes the result |
| out_op | output | 5 | Operation code (0 = none) |
| out_rd | output | 4 | Destination index |
| out_rn | output | 4 | First-source index |
| out_setf | output | 1 | Flags are updated |
| out_wr_en | output | 1 | Destination register is written |
| out_a_unused | output | 1 | Operand A is not read |
| out_illegal | output | 1 | Word is in the class but undefined |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 4-bit register indices and 15 as the special register index. With these values, every alias and illegal corner can be reached by directed words. Random words are biased toward the class and toward index 15, so the compare and move aliases and the rd = 15 illegal case come up often. Random back-pressure on out_ready exercises results held across stalls and a full register being drained and refilled in the same cycle.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 4;
  localparam int OPC_W  = 4;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 5'd0,  OP_AND = 5'd1,  OP_BIC = 5'd2,  OP_ORR = 5'd3,
    OP_ORN  = 5'd4,  OP_EOR = 5'd5,  OP_ADD = 5'd6,  OP_ADC = 5'd7,
    OP_SBC  = 5'd8,  OP_SUB = 5'd9,  OP_RSB = 5'd10, OP_TST = 5'd11,
    OP_TEQ  = 5'd12, OP_CMN = 5'd13, OP_CMP = 5'd14, OP_MOV = 5'd15,
    OP_MVN  = 5'd16
  } cdp_op_e;

  typedef struct packed {
    cdp_op_e          op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic             setf;
    logic             wr_en;
    logic             a_unused;
    logic             illegal;
  } cdp_dec_t;

  localparam int DEC_W = $bits(cdp_dec_t);
endpackage

// File: rtl/cdp_field_split.sv
module cdp_field_split
  import cdp_pkg::*;
#(
  parameter int IW = INSN_W,
  parameter int RW = REG_W,
  parameter int OW = OPC_W
) (
  input  logic [IW-1:0] insn,
  output logic          in_class,
  output logic [OW-1:0] opc,
  output logic          sbit,
  output logic [RW-1:0] rn,
  output logic [RW-1:0] rd
);
  localparam logic [4:0] CLASS_TAG = 5'b11110;

  assign in_class = (insn[IW-1 -: 5] == CLASS_TAG) && !insn[25] && !insn[15];
  assign opc      = insn[21 +: OW];
  assign sbit     = insn[20];
  assign rn       = insn[16 +: RW];
  assign rd       = insn[8 +: RW];
endmodule

// File: rtl/cdp_opcode_map.sv
module cdp_opcode_map
  import cdp_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opc,
  output cdp_op_e       base_op,
  output logic          known
);
  always_comb begin
    known = 1'b1;
    unique case (opc)
      4'd0:    base_op = OP_AND;
      4'd1:    base_op = OP_BIC;
      4'd2:    base_op = OP_ORR;
      4'd3:    base_op = OP_ORN;
      4'd4:    base_op = OP_EOR;
      4'd8:    base_op = OP_ADD;
      4'd10:   base_op = OP_ADC;
      4'd11:   base_op = OP_SBC;
      4'd13:   base_op = OP_SUB;
      4'd14:   base_op = OP_RSB;
      default: begin
        base_op = OP_NONE;
        known   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cdp_alias_resolve.sv
module cdp_alias_resolve
  import cdp_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int SPECIAL_IDX = 15
) (
  input  logic          in_class,
  input  logic          sbit,
  input  logic [RW-1:0] rn,
  input  logic [RW-1:0] rd,
  input  cdp_op_e       base_op,
  input  logic          known,
  output cdp_dec_t      dec
);
  localparam logic [RW-1:0] SPX = RW'(SPECIAL_IDX);

  logic    rd_sp, rn_sp, cmp_hit, mov_hit;
  cdp_op_e cmp_op, mov_op;

  assign rd_sp = (rd == SPX);
  assign rn_sp = (rn == SPX);

  always_comb begin
    cmp_hit = 1'b0;
    cmp_op  = OP_NONE;
    case (base_op)
      OP_AND:  begin cmp_hit = 1'b1; cmp_op = OP_TST; end
      OP_EOR:  begin cmp_hit = 1'b1; cmp_op = OP_TEQ; end
      OP_ADD:  begin cmp_hit = 1'b1; cmp_op = OP_CMN; end
      OP_SUB:  begin cmp_hit = 1'b1; cmp_op = OP_CMP; end
      default: ;
    endcase
    cmp_hit = cmp_hit && sbit && rd_sp;
  end

  always_comb begin
    mov_hit = 1'b0;
    mov_op  = OP_NONE;
    if (rn_sp) begin
      if (base_op == OP_ORR) begin mov_hit = 1'b1; mov_op = OP_MOV; end
      if (base_op == OP_ORN) begin mov_hit = 1'b1; mov_op = OP_MVN; end
    end
  end

  always_comb begin
    dec          = '0;
    dec.op       = OP_NONE;
    dec.rd       = rd;
    dec.rn       = rn;
    if (in_class) begin
      if (!known) begin
        dec.illegal = 1'b1;
      end else if (cmp_hit) begin
        dec.op   = cmp_op;
        dec.setf = 1'b1;
      end else if (rd_sp) begin
        dec.illegal = 1'b1;
      end else begin
        dec.op       = mov_hit ? mov_op : base_op;
        dec.a_unused = mov_hit;
        dec.setf     = sbit;
        dec.wr_en    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdp_out_stage.sv
module cdp_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/cdp_decoder.sv
module cdp_decoder
  import cdp_pkg::*;
#(
  parameter int IW = INSN_W,
  parameter int RW = REG_W,
  parameter int SPECIAL_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_insn,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OP_W-1:0] out_op,
  output logic [RW-1:0] out_rd,
  output logic [RW-1:0] out_rn,
  output logic          out_setf,
  output logic          out_wr_en,
  output logic          out_a_unused,
  output logic          out_illegal
);
  logic             in_class, sbit, known;
  logic [OPC_W-1:0] opc;
  logic [RW-1:0]    rn, rd;
  cdp_op_e          base_op;
  cdp_dec_t         dec, held;

  cdp_field_split #(.IW(IW), .RW(RW), .OW(OPC_W)) u_split (
    .insn(in_insn), .in_class(in_class), .opc(opc), .sbit(sbit), .rn(rn), .rd(rd)
  );

  cdp_opcode_map #(.OW(OPC_W)) u_map (
    .opc(opc), .base_op(base_op), .known(known)
  );

  cdp_alias_resolve #(.RW(RW), .SPECIAL_IDX(SPECIAL_IDX)) u_alias (
    .in_class(in_class), .sbit(sbit), .rn(rn), .rd(rd),
    .base_op(base_op), .known(known), .dec(dec)
  );

  cdp_out_stage #(.W(DEC_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(dec),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(held)
  );

  assign out_op       = held.op;
  assign out_rd       = held.rd;
  assign out_rn       = held.rn;
  assign out_setf     = held.setf;
  assign out_wr_en    = held.wr_en;
  assign out_a_unused = held.a_unused;
  assign out_illegal  = held.illegal;
endmodule

// File: rtl/cdp_decoder_chk.sv
module cdp_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [4:0] out_op,
  input logic [3:0] out_rd,
  input logic       out_setf,
  input logic       out_wr_en,
  input logic       out_a_unused,
  input logic       out_illegal
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_rd)) // R8
    else $error("stall hold");
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid) // R8
    else $error("accept");
  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wr_en && out_op == 5'd0) // R4
    else $error("illegal inert");
  AST_NO_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_en |-> out_rd != 4'd15) // R7
    else $error("pc write");
  AST_CMP_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op >= 5'd11 && out_op <= 5'd14 |-> !out_wr_en && out_setf) // R5
    else $error("compare");
  AST_A_UNUSED_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_a_unused |-> out_op == 5'd15 || out_op == 5'd16) // R6
    else $error("a unused");
endmodule

bind cdp_decoder cdp_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
  .out_rd(out_rd), .out_setf(out_setf), .out_wr_en(out_wr_en),
  .out_a_unused(out_a_unused), .out_illegal(out_illegal)
);

// File: tb/cdp_decoder_test.sv
module cdp_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [4:0]  out_op;
  logic [3:0]  out_rd, out_rn;
  logic        out_setf, out_wr_en, out_a_unused, out_illegal;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cdp_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_rd(out_rd), .out_rn(out_rn), .out_setf(out_setf),
    .out_wr_en(out_wr_en), .out_a_unused(out_a_unused), .out_illegal(out_illegal)
  );

  typedef struct packed {
    bit [4:0] op; bit [3:0] rd; bit [3:0] rn;
    bit setf; bit wr; bit au; bit ill; bit [7:0] tag;
  } exp_t;

  exp_t q[$];

  function automatic string tagname(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(bit [31:0] w);
    exp_t e;
    int o, s, n, d, b;
    e = '0;
    o = w[24:21]; s = w[20]; n = w[19:16]; d = w[11:8];
    e.rd = w[11:8]; e.rn = w[19:16];
    if (!(w[31:27] == 5'b11110 && w[25] == 0 && w[15] == 0)) begin
      e.tag = 1; return e;                                  // R1
    end
    case (o)
      0: b = 1; 1: b = 2; 2: b = 3; 3: b = 4; 4: b = 5; 8: b = 6;
      10: b = 7; 11: b = 8; 13: b = 9; 14: b = 10; default: b = 0;
    endcase
    if (b == 0) begin e.ill = 1; e.tag = 4; return e; end    // R4
    if (s == 1 && d == 15 && (o == 0 || o == 4 || o == 8 || o == 13)) begin
      e.op = (o == 0) ? 11 : (o == 4) ? 12 : (o == 8) ? 13 : 14;
      e.setf = 1; e.tag = 5; return e;                       // R5
    end
    if (d == 15) begin e.ill = 1; e.tag = 7; return e; end   // R7
    e.wr = 1; e.setf = s[0];
    if (n == 15 && o == 2) begin e.op = 15; e.au = 1; e.tag = 6; end      // R6
    else if (n == 15 && o == 3) begin e.op = 16; e.au = 1; e.tag = 6; end
    else begin e.op = b[4:0]; e.tag = (o % 2 == 0) ? 3 : 2; end          // R3 / R2
    return e;
  endfunction

  task automatic chk(bit ok, int t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tagname(t), what, act, exp);
    end
  endtask

  function automatic bit [31:0] mk(int opc, int s, int rn, int rd, int imm);
    bit [31:0] w;
    w = 32'hF000_0000;
    w[24:21] = opc[3:0]; w[20] = s[0]; w[19:16] = rn[3:0];
    w[11:8] = rd[3:0]; w[14:12] = imm[2:0]; w[7:0] = imm[10:3];
    w[26] = imm[0];
    return w;
  endfunction

  bit [31:0] stim[$];
  bit        done = 0;

  initial begin
    // Directed words
    stim.push_back(32'h0000_0000);               // R1 outside class
    stim.push_back(mk(0, 0, 1, 2, 5) | 32'h0200_0000);   // R1 bit 25 set
    stim.push_back(mk(8, 0, 3, 4, 1) | 32'h0000_8000);   // R1 bit 15 set
    for (int o = 0; o < 16; o++) stim.push_back(mk(o, 1, 5, 6, o));  // R3 R4
    stim.push_back(mk(0, 1, 2, 15, 0));          // R5 TST
    stim.push_back(mk(4, 1, 2, 15, 0));          // R5 TEQ
    stim.push_back(mk(8, 1, 2, 15, 0));          // R5 CMN
    stim.push_back(mk(13, 1, 15, 15, 0));        // R5 CMP with rn 15
    stim.push_back(mk(0, 0, 2, 15, 0));          // R7 no set-flags
    stim.push_back(mk(1, 1, 2, 15, 0));          // R7 BIC rd 15
    stim.push_back(mk(2, 0, 15, 3, 7));          // R6 MOV
    stim.push_back(mk(3, 1, 15, 3, 7));          // R6 MVN
    stim.push_back(mk(2, 1, 15, 15, 7));         // R7 MOV to rd 15
    stim.push_back(mk(14, 0, 9, 10, 2));         // R2 fields, setf 0
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 3) != 0) begin
        w[31:27] = 5'b11110; w[25] = 0; w[15] = 0;
      end
      if ($urandom_range(0, 2) == 0) w[11:8] = 4'hF;
      if ($urandom_range(0, 2) == 0) w[19:16] = 4'hF;
      stim.push_back(w);
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, 9, "out_valid after reset", out_valid, 0);   // R9
    rst_n = 1'b1;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, 8, "watchdog", cyc, 0);
        done = 1;
      end else begin
        out_ready = ($urandom_range(0, 3) != 0);
        if (!in_valid && stim.size() > 0) begin
          in_valid = 1'b1;
          in_insn  = stim.pop_front();
        end
        #1;
        chk(in_ready == (!out_valid || out_ready), 8, "in_ready", in_ready, !out_valid || out_ready); // R8
        if (out_valid && out_ready) begin
          if (q.size() == 0) chk(0, 8, "unexpected output", 1, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            chk(out_op == e.op, e.tag, "op", out_op, e.op);
            chk(out_rd == e.rd && out_rn == e.rn, 2, "rd/rn", {out_rd, out_rn}, {e.rd, e.rn});
            chk(out_setf == e.setf, e.tag, "setf", out_setf, e.setf);
            chk(out_wr_en == e.wr, e.tag, "wr_en", out_wr_en, e.wr);
            chk(out_a_unused == e.au, 6, "a_unused", out_a_unused, e.au);
            chk(out_illegal == e.ill, e.tag, "illegal", out_illegal, e.ill);
          end
        end
        if (in_valid && in_ready) begin
          q.push_back(model(in_insn));
          @(posedge clk);
          #0.5;
          in_valid = 1'b0;
        end
        if (stim.size() == 0 && !in_valid && q.size() == 0) done = 1;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule